// File: doc/BRIEF.md
# Multi-Rail Undervoltage / Overvoltage Fault Output Controller

This block sits behind a bank of threshold comparators that watch several supply rails. Each rail has a high tap, which reports "below threshold", and a low tap, which reports "above threshold". The block turns these per-rail flags into two shared active-low outputs, one for undervoltage and one for overvoltage. Each output is the OR of its fault type over all rails.

A polarity select decides whether the last two rails are watched as positive or negative supplies. On a negative rail the undervoltage and overvoltage roles of the two taps swap. Faults are stretched by a restartable timeout, given as a cycle count, and a bypass flag can remove the timeout. A supply-lockout flag overrides all other inputs.

An elaboration parameter picks one of two uses for the control pin `ov_ctl`:
- **Latch variant:** a low level on the pin makes overvoltage sticky, and a high level clears it.
- **Disable variant:** a high level silences both outputs.

Top module: `rail_supervisor_ctl`

## Requirements
- R1: While reset is applied and in the cycle after it is released, `uv_n` is 0 and `ov_n` is 1.
- R2: On a positive rail (rails 0 and 1 always, rails 2 and 3 when selected positive), `hi_below[i]` is an undervoltage fault and `lo_above[i]` is an overvoltage fault. A fault sampled at a clock edge drives its output low from that edge on.
- R3: On a negative rail the tap roles swap: `hi_below[i]` is an overvoltage fault and `lo_above[i]` is an undervoltage fault.
- R4: `pol_sel` sets the polarity of rails 2 and 3:
  - 2'b01 makes both rails positive.
  - 2'b10 and 2'b11 make rail 2 positive and rail 3 negative.
  - 2'b00 makes both rails negative.
- R5: Both outputs are active low. Each goes low when a fault of its type is present on any rail, including several rails at the same time.
- R6: After the last clock edge at which an undervoltage fault is sampled, `uv_n` stays low for `timeout_cyc` further edges and rises at the edge after that. A new fault during this window restarts the full count.
- R7: With `timer_bypass` at 1 the timeout is zero. Each output rises at the first clock edge at which its fault is no longer sampled.
- R8: In the latch variant, an overvoltage fault sampled while `ov_ctl` is 0 holds `ov_n` low, even after the fault has gone. `ov_n` is released only once `ov_ctl` is 1.
- R9: In the latch variant, while `ov_ctl` is 1 the output `ov_n` is stretched with the same timeout as `uv_n`. If `ov_ctl` drops to 0 while `ov_n` is still low, `ov_n` becomes latched.
- R10: In the disable variant, while `ov_ctl` is 1 both outputs are high whatever the faults, with one exception: `supply_lock` drives `uv_n` low. In that case `uv_n` rises at the first edge at which the lockout is no longer sampled, with no timeout.
- R11: `supply_lock` drives `uv_n` low and `ov_n` high, and clears any overvoltage latch. When the block is not disabled, recovery from lockout runs the same timeout as an undervoltage fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_below | input | RAILS | Per-rail high-tap comparator result, 1 when below threshold |
| lo_above | input | RAILS | Per-rail low-tap comparator result, 1 when above threshold |
| pol_sel | input | 2 | Polarity code for the last two rails |
| supply_lock | input | 1 | Supply undervoltage lockout active |
| timeout_cyc | input | CNT_W | Stretch length in clock cycles |
| timer_bypass | input | 1 | 1 removes the timeout |
| ov_ctl | input | 1 | Latch-release input (latch variant) or disable input (disable variant) |
| uv_n | output | 1 | Undervoltage output, active low |
| ov_n | output | 1 | Overvoltage output, active low |

## Verification
The checker assumes that the comparator flags, the polarity code and the control pin are synchronous to `clk` and hold steady for a whole cycle. It also assumes that rails 0 and 1 are always positive. For this reason its fault properties watch only rail 0, and they leave the polarity-dependent rails to the bench model. The bench changes every input only on the falling clock edge, which keeps each value stable around the sampling edge. It uses a short timeout so that restart and expiry windows fit within a few cycles. It also drives both variants with identical rail stimulus, so the latch and disable behaviours can be compared against the same fault history.

// File: rtl/sup_pkg.sv
package sup_pkg;

   typedef enum logic [1:0] {
      POL_NEG_BOTH  = 2'b00,
      POL_POS_BOTH  = 2'b01,
      POL_SPLIT     = 2'b10,
      POL_SPLIT_ALT = 2'b11
   } pol_sel_e;

   localparam int OVCTL_LATCH   = 0;
   localparam int OVCTL_DISABLE = 1;

   // Rails below rails-2 are fixed positive; the last two follow the select code.
   function automatic logic rail_is_neg(input int idx, input int rails,
                                        input logic [1:0] sel);
      logic neg;
      neg = 1'b0;
      if (idx == rails - 2)
         neg = (sel == POL_NEG_BOTH);
      else if (idx == rails - 1)
         neg = (sel != POL_POS_BOTH);
      return neg;
   endfunction

endpackage

// File: rtl/sup_fault_map.sv
module sup_fault_map
   import sup_pkg::*;
#(
   parameter int RAILS = 4
) (
   input  logic [RAILS-1:0] hi_below,
   input  logic [RAILS-1:0] lo_above,
   input  logic [1:0]       pol_sel,
   output logic             uv_any,
   output logic             ov_any
);

   logic [RAILS-1:0] uv_vec;
   logic [RAILS-1:0] ov_vec;

   for (genvar g = 0; g < RAILS; g++) begin : g_rail
      logic neg;
      assign neg       = rail_is_neg(g, RAILS, pol_sel);
      assign uv_vec[g] = neg ? lo_above[g] : hi_below[g];
      assign ov_vec[g] = neg ? hi_below[g] : lo_above[g];
   end

   assign uv_any = |uv_vec;
   assign ov_any = |ov_vec;

endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
   parameter int   CNT_W      = 16,
   parameter logic RST_ACTIVE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             direct,
   input  logic             fault,
   input  logic [CNT_W-1:0] load_val,
   output logic             active
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         active <= RST_ACTIVE;
      end else if (direct) begin
         cnt    <= '0;
         active <= fault;
      end else if (fault) begin
         cnt    <= load_val;
         active <= 1'b1;
      end else if (cnt != '0) begin
         cnt    <= cnt - 1'b1;
      end else begin
         active <= 1'b0;
      end
   end

endmodule

// File: rtl/sup_ov_latch.sv
module sup_ov_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic hold_req,
   output logic latched
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         latched <= 1'b0;
      else if (clear)
         latched <= 1'b0;
      else if (hold_req)
         latched <= 1'b1;
   end

endmodule

// File: rtl/rail_supervisor_ctl.sv
module rail_supervisor_ctl
   import sup_pkg::*;
#(
   parameter int RAILS       = 4,
   parameter int CNT_W       = 16,
   parameter int OV_CTL_MODE = OVCTL_LATCH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RAILS-1:0] hi_below,
   input  logic [RAILS-1:0] lo_above,
   input  logic [1:0]       pol_sel,
   input  logic             supply_lock,
   input  logic [CNT_W-1:0] timeout_cyc,
   input  logic             timer_bypass,
   input  logic             ov_ctl,
   output logic             uv_n,
   output logic             ov_n
);

   localparam logic [CNT_W-1:0] NO_WAIT = '0;

   if (RAILS < 2) begin : g_bad_rails
      $error("rail_supervisor_ctl: RAILS must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("rail_supervisor_ctl: CNT_W must be at least 1");
   end
   if (OV_CTL_MODE != OVCTL_LATCH && OV_CTL_MODE != OVCTL_DISABLE) begin : g_bad_mode
      $error("rail_supervisor_ctl: unknown OV_CTL_MODE");
   end

   logic             uv_any, ov_any;
   logic             dis_on;
   logic             ov_latched;
   logic             uv_act, ov_act;
   logic [CNT_W-1:0] load_val;

   sup_fault_map #(.RAILS(RAILS)) map_i (
      .hi_below (hi_below),
      .lo_above (lo_above),
      .pol_sel  (pol_sel),
      .uv_any   (uv_any),
      .ov_any   (ov_any)
   );

   assign load_val = timer_bypass ? NO_WAIT : timeout_cyc;

   sup_stretch #(.CNT_W(CNT_W), .RST_ACTIVE(1'b1)) uv_str_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .direct   (dis_on),
      .fault    (supply_lock | (uv_any & ~dis_on)),
      .load_val (load_val),
      .active   (uv_act)
   );

   sup_stretch #(.CNT_W(CNT_W), .RST_ACTIVE(1'b0)) ov_str_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .direct   (dis_on | supply_lock),
      .fault    (ov_any & ~dis_on & ~supply_lock),
      .load_val (load_val),
      .active   (ov_act)
   );

   if (OV_CTL_MODE == OVCTL_DISABLE) begin : g_disable
      assign dis_on     = ov_ctl;
      assign ov_latched = 1'b0;
   end else begin : g_latch
      assign dis_on = 1'b0;
      sup_ov_latch latch_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .clear    (supply_lock | ov_ctl),
         .hold_req (ov_any | ov_act),
         .latched  (ov_latched)
      );
   end

   assign uv_n = ~uv_act;
   assign ov_n = ~(ov_act | ov_latched);

endmodule

// File: rtl/sup_ctl_chk.sv
module sup_ctl_chk
   import sup_pkg::*;
#(
   parameter int RAILS       = 4,
   parameter int OV_CTL_MODE = OVCTL_LATCH
) (
   input logic             clk,
   input logic             rst_n,
   input logic [RAILS-1:0] hi_below,
   input logic [RAILS-1:0] lo_above,
   input logic             supply_lock,
   input logic             ov_ctl,
   input logic             uv_n,
   input logic             ov_n
);

   logic dis_in;
   assign dis_in = (OV_CTL_MODE == OVCTL_DISABLE) && ov_ctl;

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!uv_n && ov_n));

   assert_uv_rail0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_below[0] && !dis_in) |=> !uv_n);

   assert_ov_rail0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_above[0] && !supply_lock && !dis_in) |=> !ov_n);

   assert_lock_outputs_R11: assert property (@(posedge clk) disable iff (!rst_n)
      supply_lock |=> (!uv_n && ov_n));

   assert_uv_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uv_n) |-> !$past(supply_lock));

   if (OV_CTL_MODE == OVCTL_DISABLE) begin : g_dis_chk
      assert_dis_ov_R10: assert property (@(posedge clk) disable iff (!rst_n)
         ov_ctl |=> ov_n);
      assert_dis_uv_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (ov_ctl && !supply_lock) |=> uv_n);
   end else begin : g_latch_chk
      assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (!ov_n && !ov_ctl && !supply_lock) |=> !ov_n);
   end

endmodule

bind rail_supervisor_ctl sup_ctl_chk #(
   .RAILS       (RAILS),
   .OV_CTL_MODE (OV_CTL_MODE)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .hi_below    (hi_below),
   .lo_above    (lo_above),
   .supply_lock (supply_lock),
   .ov_ctl      (ov_ctl),
   .uv_n        (uv_n),
   .ov_n        (ov_n)
);

// File: tb/rail_supervisor_ctl_tb.sv
module rail_supervisor_ctl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int RAILS      = 4;
   localparam int CNT_W      = 16;
   localparam int TMO        = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [RAILS-1:0] hi_below = '0;
   logic [RAILS-1:0] lo_above = '0;
   logic [1:0]       pol_sel = 2'b01;
   logic             supply_lock = 1'b0;
   logic [CNT_W-1:0] timeout_cyc = CNT_W'(TMO);
   logic             timer_bypass = 1'b0;
   logic             latch_ctl = 1'b1;
   logic             dis_ctl = 1'b0;
   logic             uv_n_l, ov_n_l, uv_n_d, ov_n_d;

   int    n_checks = 0;
   int    n_fail   = 0;
   string phase_req = "R1";
   bit    finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rail_supervisor_ctl #(.RAILS(RAILS), .CNT_W(CNT_W), .OV_CTL_MODE(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .hi_below(hi_below), .lo_above(lo_above),
      .pol_sel(pol_sel), .supply_lock(supply_lock), .timeout_cyc(timeout_cyc),
      .timer_bypass(timer_bypass), .ov_ctl(latch_ctl), .uv_n(uv_n_l), .ov_n(ov_n_l));

   rail_supervisor_ctl #(.RAILS(RAILS), .CNT_W(CNT_W), .OV_CTL_MODE(1)) dut_dis_i (
      .clk(clk), .rst_n(rst_n), .hi_below(hi_below), .lo_above(lo_above),
      .pol_sel(pol_sel), .supply_lock(supply_lock), .timeout_cyc(timeout_cyc),
      .timer_bypass(timer_bypass), .ov_ctl(dis_ctl), .uv_n(uv_n_d), .ov_n(ov_n_d));

   // ---------------- behavioural reference model (index 0 latch, 1 disable)
   int uv_left[2], ov_left[2];
   bit uv_on[2], ov_on[2];
   bit ov_stick;

   function automatic bit negative_rail(int r, logic [1:0] s);
      if (r == 2) return s == 2'b00;
      if (r == 3) return !(s == 2'b01);
      return 1'b0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (uv_on[k]) begin
            uv_on[k] = 1'b1; ov_on[k] = 1'b0; uv_left[k] = 0; ov_left[k] = 0;
         end
         ov_stick = 1'b0;
      end else begin
         bit uvf, ovf, prev_ov;
         int span;
         uvf = 0; ovf = 0;
         for (int r = 0; r < RAILS; r++) begin
            if (negative_rail(r, pol_sel)) begin
               uvf |= lo_above[r]; ovf |= hi_below[r];
            end else begin
               uvf |= hi_below[r]; ovf |= lo_above[r];
            end
         end
         span = timer_bypass ? 0 : int'(timeout_cyc);
         prev_ov = ov_on[0];
         for (int v = 0; v < 2; v++) begin
            bit off;
            off = (v == 1) && dis_ctl;
            if (off) begin
               uv_on[v] = supply_lock; uv_left[v] = 0;
            end else if (uvf || supply_lock) begin
               uv_on[v] = 1; uv_left[v] = span;
            end else if (uv_left[v] > 0) uv_left[v]--;
            else uv_on[v] = 0;
            if (off || supply_lock) begin
               ov_on[v] = 0; ov_left[v] = 0;
            end else if (ovf) begin
               ov_on[v] = 1; ov_left[v] = span;
            end else if (ov_left[v] > 0) ov_left[v]--;
            else ov_on[v] = 0;
         end
         if (supply_lock || latch_ctl) ov_stick = 0;
         else if (ovf || prev_ov) ov_stick = 1;
      end
   end

   task automatic chk(string req, string what, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(phase_req, "latch uv_n", uv_n_l, !uv_on[0]);
         chk(phase_req, "latch ov_n", ov_n_l, !(ov_on[0] || ov_stick));
         chk(phase_req, "dis uv_n",   uv_n_d, !uv_on[1]);
         chk(phase_req, "dis ov_n",   ov_n_d, !ov_on[1]);
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_hi(int r);
      hi_below[r] = 1'b1; idle(1); hi_below[r] = 1'b0;
   endtask

   task automatic pulse_lo(int r);
      lo_above[r] = 1'b1; idle(1); lo_above[r] = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         finished = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      // R1: reset state on both variants
      chk("R1", "latch uv_n in reset", uv_n_l, 1'b0);
      chk("R1", "latch ov_n in reset", ov_n_l, 1'b1);
      chk("R1", "dis uv_n in reset", uv_n_d, 1'b0);
      chk("R1", "dis ov_n in reset", ov_n_d, 1'b1);
      rst_n = 1'b1;
      idle(4);

      // R11: lockout then timed recovery
      phase_req = "R11";
      supply_lock = 1'b1; idle(4); supply_lock = 1'b0; idle(TMO + 4);

      // R2 / R6: positive undervoltage on rail 0, restart on rail 1
      phase_req = "R6";
      pulse_hi(0); idle(3); pulse_hi(1); idle(2);
      chk("R6", "uv_n held during restarted window", uv_n_l, 1'b0);
      idle(TMO + 3);
      chk("R6", "uv_n released after window", uv_n_l, 1'b1);
      phase_req = "R2";
      pulse_lo(0); idle(TMO + 3);

      // R9: latch input high, overvoltage stretched like undervoltage
      phase_req = "R9";
      pulse_lo(1); idle(2);
      chk("R9", "ov_n stretched", ov_n_l, 1'b0);
      idle(TMO + 2);
      // R9: drop latch input while stretch still running
      pulse_lo(0); idle(2); latch_ctl = 1'b0; idle(TMO + 4);
      chk("R9", "ov_n latched after mid-window drop", ov_n_l, 1'b0);
      latch_ctl = 1'b1; idle(3);

      // R5: several rails at once, both fault types
      phase_req = "R5";
      hi_below = 4'b0011; lo_above = 4'b0110; idle(3);
      hi_below = '0; lo_above = '0; idle(TMO + 3);

      // R3 / R4: every polarity code with each tap of rails 2 and 3
      for (int s = 0; s < 4; s++) begin
         pol_sel = 2'(s);
         phase_req = (s == 2'b01) ? "R4" : "R3";
         idle(2);
         pulse_hi(2); idle(TMO + 3);
         pulse_lo(2); idle(TMO + 3);
         pulse_hi(3); idle(TMO + 3);
         pulse_lo(3); idle(TMO + 3);
      end
      pol_sel = 2'b00; idle(1);
      pulse_lo(3); idle(1);
      chk("R3", "negative rail 3 low tap is undervoltage", uv_n_l, 1'b0);
      chk("R3", "negative rail 3 low tap not overvoltage", ov_n_l, 1'b1);
      idle(TMO + 3);
      pol_sel = 2'b01; idle(2);

      // R7: bypassed timer
      phase_req = "R7";
      timer_bypass = 1'b1;
      pulse_hi(0); idle(1);
      chk("R7", "uv_n follows without timeout", uv_n_l, 1'b1);
      pulse_lo(1); idle(3);
      hi_below[1] = 1'b1; idle(3); hi_below[1] = 1'b0; idle(3);
      timer_bypass = 1'b0;

      // R8: latched overvoltage
      phase_req = "R8";
      latch_ctl = 1'b0; idle(1);
      pulse_lo(1); idle(TMO + 10);
      chk("R8", "ov_n stays latched", ov_n_l, 1'b0);
      chk("R8", "disable variant ov_n released", ov_n_d, 1'b1);
      latch_ctl = 1'b1; idle(2);
      chk("R8", "latch cleared by high input", ov_n_l, 1'b1);
      idle(2);

      // R10: disable variant
      phase_req = "R10";
      dis_ctl = 1'b1; idle(1);
      hi_below = 4'b1111; lo_above = 4'b1111; idle(4);
      chk("R10", "disabled uv_n high", uv_n_d, 1'b1);
      chk("R10", "disabled ov_n high", ov_n_d, 1'b1);
      hi_below = '0; lo_above = '0; idle(TMO + 3);
      supply_lock = 1'b1; idle(3);
      chk("R10", "lockout asserts uv_n while disabled", uv_n_d, 1'b0);
      supply_lock = 1'b0; idle(1);
      chk("R10", "uv_n releases without timeout", uv_n_d, 1'b1);
      idle(3);
      dis_ctl = 1'b0; idle(3);

      // R11: lockout forces overvoltage off and clears latch
      phase_req = "R11";
      latch_ctl = 1'b0; lo_above[0] = 1'b1; idle(3);
      supply_lock = 1'b1; idle(2);
      chk("R11", "ov_n forced high under lockout", ov_n_l, 1'b1);
      chk("R11", "uv_n low under lockout", uv_n_l, 1'b0);
      lo_above[0] = 1'b0; idle(1);
      supply_lock = 1'b0; latch_ctl = 1'b1; idle(TMO + 4);
      chk("R11", "uv_n recovered after timeout", uv_n_l, 1'b1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule